// File: doc/BRIEF.md
# Single-Register Performance Monitor

This block counts processor activity for profiling. It holds three 32-bit counters: one that advances on clock cycles and two that each count a chosen event. A core drives a vector of one-cycle event pulses, and each event counter picks one pulse line through an 8-bit event code.

All configuration and status sit in one control register. That register holds the run enable, a prescale option for the cycle counter, one-shot counter clears, per-counter interrupt enables, sticky overflow flags and the two event codes. Software clears an overflow flag by writing a 1 to its position, so an interrupt handler can acknowledge an overflow by writing back the value it just read.

A simple register port gives access to the control register and to each counter: a valid strobe, a write strobe, a 2-bit index, write data, and read data that follows the index combinationally. The interrupt line is a level. It is high while any overflow flag is set and its enable is set.

Top module: `perfmon_unit`

## Requirements
- R1: After reset all three counters read 0, the interrupt is low, and the control register reads 0x0FFFF000 (both event codes 0xFF, every other field 0).
- R2: Control register layout: bit 0 run enable, bit 1 clear both event counters, bit 2 clear cycle counter, bit 3 prescale, bits 4/5/6 interrupt enables (event 0, event 1, cycle), bits 8/9/10 overflow flags (same order), bits 19:12 event code of counter 0, bits 27:20 event code of counter 1. Bits 1, 2, 7, 11 and 31:28 always read 0. Writing all ones reads back 0x0FFFF079.
- R3: While enabled, an event counter adds 1 at each clock edge where evt_pulse[code] is high. Codes 0x00 to 0x1F select evt_pulse bits 0 to 31.
- R4: An event counter whose code is 0xFF, or any code of 0x20 or above with the default 32 event lines, never increments.
- R5: With bit 0 clear no counter advances. Counter values and flags are kept, and they can still be read and written.
- R6: While enabled, the cycle counter adds 1 every clock. With the prescale bit set it adds 1 once per 64 enabled clocks, counted from the last cycle-counter clear.
- R7: Writing 1 to bit 1 zeroes both event counters, and writing 1 to bit 2 zeroes the cycle counter (and the prescale phase). Each acts once and leaves the other counters untouched.
- R8: Register index 1 is the cycle counter, index 2 is event counter 0 and index 3 is event counter 1. A counter write takes priority over an increment in the same cycle.
- R9: A counter stepping from 0xFFFFFFFF to 0 sets its overflow flag.
- R10: Writing 1 to a flag position clears that flag, and writing 0 leaves it. If a wrap occurs in the same cycle as the clear, the flag stays set.
- R11: irq is high exactly when some overflow flag and its interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_index | input | 2 | 0 control, 1 cycle counter, 2 event counter 0, 3 event counter 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_index (combinational) |
| evt_pulse | input | 32 | One-cycle event pulses from the core |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle. The first is a counter wrapping while software writes 1 to clear that counter's flag. The bench preloads event counter 0 to all ones, raises its selected pulse and writes the flag-clear in the same clock. It then expects flag 8 still set and irq high, while flag 9, cleared in that same write, is gone. The second is a counter write in the same cycle as a counted event; here the written value must win exactly, with no extra increment.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int CTRL_W  = 32;
    localparam int NUM_CNT = 3;
    localparam int SEL_W   = 8;

    // control bit positions
    localparam int B_EN     = 0;
    localparam int B_EVRST  = 1;
    localparam int B_CYCRST = 2;
    localparam int B_PRESC  = 3;
    localparam int B_IE     = 4;
    localparam int B_FLAG   = 8;
    localparam int B_SEL0   = 12;
    localparam int B_SEL1   = 20;

    // counter slots: order matches enable and flag bit order
    localparam int CI_EV0 = 0;
    localparam int CI_EV1 = 1;
    localparam int CI_CYC = 2;

    localparam logic [SEL_W-1:0]  SEL_NONE  = 8'hFF;
    localparam logic [CTRL_W-1:0] RSVD_MASK = 32'hF000_0886;

    typedef enum logic [1:0] {
        RI_CTRL = 2'd0,
        RI_CYC  = 2'd1,
        RI_EV0  = 2'd2,
        RI_EV1  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel1;
        logic [SEL_W-1:0]   sel0;
        logic [NUM_CNT-1:0] flag;
        logic [NUM_CNT-1:0] ie;
        logic               presc;
        logic               en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{sel1: SEL_NONE, sel0: SEL_NONE,
                                   flag: '0, ie: '0, presc: 1'b0, en: 1'b0};

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] r;
        r = '0;
        r[B_EN]              = c.en;
        r[B_PRESC]           = c.presc;
        r[B_IE +: NUM_CNT]   = c.ie;
        r[B_FLAG +: NUM_CNT] = c.flag;
        r[B_SEL0 +: SEL_W]   = c.sel0;
        r[B_SEL1 +: SEL_W]   = c.sel1;
        return r;
    endfunction

endpackage

// File: rtl/perfmon_evsel.sv
module perfmon_evsel
    import perfmon_pkg::*;
#(
    parameter int NUM_EVT = 32
) (
    input  logic [NUM_EVT-1:0] pulses,
    input  logic [SEL_W-1:0]   code,
    output logic               hit
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic in_range;

    always_comb begin
        in_range = (32'(code) < NUM_EVT) && (code != SEL_NONE);
        hit      = in_range ? pulses[code[IDX_W-1:0]] : 1'b0;
    end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         wrap
);
    always_comb wrap = inc && !load && !clr && (&q);

    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (load)  q <= load_val;
        else if (inc)   q <= q + 1'b1;
    end

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (q == $past(load_val)));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load && !clr) |=> $stable(q));
endmodule

// File: rtl/perfmon_prescale.sv
module perfmon_prescale #(
    parameter int DIV_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic slow,
    output logic tick
);
    logic [DIV_W-1:0] phase;

    always_comb tick = run && (!slow || (&phase));

    always_ff @(posedge clk) begin
        if (rst || clr) phase <= '0;
        else if (run)   phase <= phase + 1'b1;
    end

    // R6
    presc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [NUM_CNT-1:0] wrap,
    output ctrl_t             ctrl,
    output logic              clr_ev,
    output logic              clr_cyc
);
    logic [NUM_CNT-1:0] ack;
    logic [NUM_CNT-1:0] flag_nxt;

    always_comb begin
        ack      = wr ? wdata[B_FLAG +: NUM_CNT] : '0;
        flag_nxt = (ctrl.flag & ~ack) | wrap;
        clr_ev   = wr && wdata[B_EVRST];
        clr_cyc  = wr && wdata[B_CYCRST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
        end else begin
            if (wr) begin
                ctrl.en    <= wdata[B_EN];
                ctrl.presc <= wdata[B_PRESC];
                ctrl.ie    <= wdata[B_IE +: NUM_CNT];
                ctrl.sel0  <= wdata[B_SEL0 +: SEL_W];
                ctrl.sel1  <= wdata[B_SEL1 +: SEL_W];
            end
            ctrl.flag <= flag_nxt;
        end
    end

    // R9, R10: a wrap always leaves its flag set, even against a clear
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |=> ((ctrl.flag & $past(wrap)) == $past(wrap)));

    // R10
    flag_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ack & ~wrap)) |=> ((ctrl.flag & $past(ack & ~wrap)) == '0));
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 32,
    parameter int DIV_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [1:0]         reg_index,
    input  logic [CTRL_W-1:0]  reg_wdata,
    output logic [CTRL_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);
    ctrl_t              ctrl;
    logic               bus_wr;
    logic               clr_ev, clr_cyc;
    logic               cyc_tick;
    logic [1:0]         ev_hit;
    logic [SEL_W-1:0]   sel_code [2];
    logic [NUM_CNT-1:0] inc, load, clr, wrap;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    always_comb begin
        bus_wr       = reg_valid && reg_write;
        sel_code[0]  = ctrl.sel0;
        sel_code[1]  = ctrl.sel1;
        load[CI_EV0] = bus_wr && (reg_index == RI_EV0);
        load[CI_EV1] = bus_wr && (reg_index == RI_EV1);
        load[CI_CYC] = bus_wr && (reg_index == RI_CYC);
        clr[CI_EV0]  = clr_ev;
        clr[CI_EV1]  = clr_ev;
        clr[CI_CYC]  = clr_cyc;
        inc[CI_EV0]  = ctrl.en && ev_hit[0];
        inc[CI_EV1]  = ctrl.en && ev_hit[1];
        inc[CI_CYC]  = cyc_tick;
    end

    perfmon_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr && (reg_index == RI_CTRL)),
        .wdata   (reg_wdata),
        .wrap    (wrap),
        .ctrl    (ctrl),
        .clr_ev  (clr_ev),
        .clr_cyc (clr_cyc)
    );

    perfmon_prescale #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_cyc),
        .run  (ctrl.en),
        .slow (ctrl.presc),
        .tick (cyc_tick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_sel
        perfmon_evsel #(.NUM_EVT(NUM_EVT)) u_sel (
            .pulses (evt_pulse),
            .code   (sel_code[g]),
            .hit    (ev_hit[g])
        );
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        perfmon_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr[g]),
            .load     (load[g]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .inc      (inc[g]),
            .q        (cnt_q[g]),
            .wrap     (wrap[g])
        );
    end

    always_comb begin
        case (reg_index)
            RI_CTRL: reg_rdata = ctrl_pack(ctrl);
            RI_CYC:  reg_rdata = CTRL_W'(cnt_q[CI_CYC]);
            RI_EV0:  reg_rdata = CTRL_W'(cnt_q[CI_EV0]);
            default: reg_rdata = CTRL_W'(cnt_q[CI_EV1]);
        endcase
        irq = |(ctrl.flag & ctrl.ie);
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_index == RI_CTRL) |-> ((reg_rdata & RSVD_MASK) == '0));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ie == '0) |-> !irq);

    // R5
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !(|load) && !(|clr)) |=> $stable(cnt_q[CI_EV0]));
endmodule

// File: tb/perfmon_unit_bench.sv
module perfmon_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [1:0]  reg_index = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    localparam logic [1:0] IX_CTRL = 2'd0, IX_CYC = 2'd1, IX_EV0 = 2'd2, IX_EV1 = 2'd3;

    typedef struct packed {
        logic [7:0]  s0;
        logic [7:0]  s1;
        logic [7:0]  b;
        logic [7:0]  n;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h07, 8'h05, 8'd7,  8'd5, 32'd5, 32'd0},
        '{8'h07, 8'h05, 8'd5,  8'd3, 32'd0, 32'd3},
        '{8'h0B, 8'h0B, 8'd11, 8'd4, 32'd4, 32'd4},
        '{8'hFF, 8'h0A, 8'd10, 8'd6, 32'd0, 32'd6},
        '{8'h00, 8'h40, 8'd0,  8'd2, 32'd2, 32'd0},
        '{8'h06, 8'h1F, 8'd31, 8'd1, 32'd0, 32'd1}
    };

    perfmon_unit u_perfmon_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_index (reg_index),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ctl(input bit en, input bit presc, input logic [2:0] ie,
                                        input logic [7:0] s0, input logic [7:0] s1,
                                        input logic [2:0] fl, input bit rev, input bit rcyc);
        return {4'b0, s1, s0, 1'b0, fl, 1'b0, ie, presc, rcyc, rev, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_index = idx; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_index = idx;
        #1 v = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] pat, input int n);
        repeat (n) begin
            @(negedge clk);
            evt_pulse = pat;
        end
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(IX_CTRL, v); chk("R1 ctrl", v, 32'h0FFF_F000);
        rd(IX_CYC, v);  chk("R1 cyc", v, 0);
        rd(IX_EV0, v);  chk("R1 ev0", v, 0);
        rd(IX_EV1, v);  chk("R1 ev1", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R3 / R4 table of event selections
        foreach (VECS[i]) begin
            wr(IX_EV0, 0);
            wr(IX_EV1, 0);
            wr(IX_CTRL, ctl(1, 0, 3'b000, VECS[i].s0, VECS[i].s1, 3'b000, 0, 0));
            pulse(32'd1 << VECS[i].b, int'(VECS[i].n));
            wr(IX_CTRL, ctl(0, 0, 3'b000, VECS[i].s0, VECS[i].s1, 3'b000, 0, 0));
            rd(IX_EV0, v); chk("R3/R4 table ev0", v, VECS[i].e0);
            rd(IX_EV1, v); chk("R3/R4 table ev1", v, VECS[i].e1);
        end

        // R4 code 0xFF with every line pulsing
        wr(IX_EV0, 0); wr(IX_EV1, 0);
        wr(IX_CTRL, ctl(1, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        pulse('1, 10);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        rd(IX_EV0, v); chk("R4 none ev0", v, 0);
        rd(IX_EV1, v); chk("R4 none ev1", v, 0);

        // R5 disabled: hold, still writable
        wr(IX_EV0, 32'h1234); wr(IX_EV1, 32'h20); wr(IX_CYC, 32'h55);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'h07, 8'h07, 3'b000, 0, 0));
        pulse(32'd1 << 7, 5);
        rd(IX_EV0, v); chk("R5 ev0 held", v, 32'h1234);
        rd(IX_EV1, v); chk("R5 ev1 held", v, 32'h20);
        rd(IX_CYC, v); chk("R5 cyc held", v, 32'h55);

        // R6 cycle counting: enable window spans k+2 edges
        wr(IX_CYC, 0);
        wr(IX_CTRL, ctl(1, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        repeat (8) @(negedge clk);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        rd(IX_CYC, v); chk("R6 cyc every clock", v, 10);

        wr(IX_CTRL, ctl(1, 1, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 1));
        repeat (60) @(negedge clk);
        wr(IX_CTRL, ctl(0, 1, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        rd(IX_CYC, v); chk("R6 prescale 62 clocks", v, 0);

        wr(IX_CTRL, ctl(1, 1, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 1));
        repeat (126) @(negedge clk);
        wr(IX_CTRL, ctl(0, 1, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        rd(IX_CYC, v); chk("R6 prescale 128 clocks", v, 2);

        // R7 clear bits
        wr(IX_EV0, 5); wr(IX_EV1, 6); wr(IX_CYC, 7);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 1, 0));
        rd(IX_EV0, v); chk("R7 ev0 cleared", v, 0);
        rd(IX_EV1, v); chk("R7 ev1 cleared", v, 0);
        rd(IX_CYC, v); chk("R7 cyc kept", v, 7);
        rd(IX_CTRL, v); chk("R7 clear bits read 0", v, ctl(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 1));
        rd(IX_CYC, v); chk("R7 cyc cleared", v, 0);

        // R2 forced-zero positions
        wr(IX_CTRL, 32'hFFFF_FFFF);
        rd(IX_CTRL, v); chk("R2 all ones readback", v, 32'h0FFF_F079);
        chk("R2 irq no flags", {31'b0, irq}, 0);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'hFF, 8'hFF, 3'b000, 0, 0));

        // R9 / R11 event 0 wrap
        wr(IX_EV0, 32'hFFFF_FFFE);
        wr(IX_CTRL, ctl(1, 0, 3'b001, 8'h07, 8'hFF, 3'b000, 0, 0));
        pulse(32'd1 << 7, 2);
        wr(IX_CTRL, ctl(0, 0, 3'b001, 8'h07, 8'hFF, 3'b000, 0, 0));
        rd(IX_EV0, v); chk("R9 ev0 wrapped", v, 0);
        rd(IX_CTRL, v); chk("R9 flag8 set", v & 32'h700, 32'h100);
        chk("R11 irq high", {31'b0, irq}, 1);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'h07, 8'hFF, 3'b000, 0, 0));
        chk("R11 irq masked", {31'b0, irq}, 0);
        rd(IX_CTRL, v); chk("R10 zero write keeps flag", v & 32'h700, 32'h100);
        wr(IX_CTRL, ctl(0, 0, 3'b001, 8'h07, 8'hFF, 3'b000, 0, 0));
        chk("R11 irq unmasked", {31'b0, irq}, 1);
        wr(IX_CTRL, ctl(0, 0, 3'b001, 8'h07, 8'hFF, 3'b001, 0, 0));
        rd(IX_CTRL, v); chk("R10 flag cleared", v & 32'h700, 0);
        chk("R10 irq after clear", {31'b0, irq}, 0);

        // R10 wrap and clear in the same cycle
        wr(IX_EV1, 32'hFFFF_FFFF);
        wr(IX_CTRL, ctl(1, 0, 3'b010, 8'hFF, 8'h08, 3'b000, 0, 0));
        pulse(32'd1 << 8, 1);
        wr(IX_CTRL, ctl(0, 0, 3'b011, 8'h07, 8'h08, 3'b000, 0, 0));
        rd(IX_CTRL, v); chk("R9 flag9 set", v & 32'h700, 32'h200);
        wr(IX_EV0, 32'hFFFF_FFFF);
        wr(IX_CTRL, ctl(1, 0, 3'b011, 8'h07, 8'h08, 3'b000, 0, 0));
        @(negedge clk);
        evt_pulse = 32'd1 << 7;
        reg_valid = 1'b1; reg_write = 1'b1; reg_index = IX_CTRL;
        reg_wdata = ctl(1, 0, 3'b011, 8'h07, 8'h08, 3'b011, 0, 0);
        @(negedge clk);
        evt_pulse = '0; reg_valid = 1'b0; reg_write = 1'b0;
        wr(IX_CTRL, ctl(0, 0, 3'b011, 8'h07, 8'h08, 3'b000, 0, 0));
        rd(IX_CTRL, v); chk("R10 wrap beats clear", v & 32'h700, 32'h100);
        rd(IX_EV0, v); chk("R10 ev0 wrapped", v, 0);
        chk("R11 irq from wrap", {31'b0, irq}, 1);
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'h07, 8'hFF, 3'b001, 0, 0));

        // R8 counter write beats increment
        wr(IX_CTRL, ctl(1, 0, 3'b000, 8'h07, 8'hFF, 3'b000, 0, 0));
        @(negedge clk);
        evt_pulse = 32'd1 << 7;
        reg_valid = 1'b1; reg_write = 1'b1; reg_index = IX_EV0; reg_wdata = 32'h100;
        @(negedge clk);
        evt_pulse = '0; reg_valid = 1'b0; reg_write = 1'b0;
        wr(IX_CTRL, ctl(0, 0, 3'b000, 8'h07, 8'hFF, 3'b000, 0, 0));
        rd(IX_EV0, v); chk("R8 write wins", v, 32'h100);
        wr(IX_CYC, 32'hA5A5_0001);
        rd(IX_CYC, v); chk("R8 cyc write", v, 32'hA5A5_0001);
        wr(IX_EV1, 32'h0BAD_F00D);
        rd(IX_EV1, v); chk("R8 ev1 write", v, 32'h0BAD_F00D);

        // R9 cycle counter wrap
        wr(IX_CYC, 32'hFFFF_FFFF);
        wr(IX_CTRL, ctl(1, 0, 3'b100, 8'hFF, 8'hFF, 3'b000, 0, 0));
        wr(IX_CTRL, ctl(0, 0, 3'b100, 8'hFF, 8'hFF, 3'b000, 0, 0));
        rd(IX_CYC, v);  chk("R9 cyc after wrap", v, 1);
        rd(IX_CTRL, v); chk("R9 flag10 set", v & 32'h700, 32'h400);
        chk("R11 irq cycle", {31'b0, irq}, 1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule